// File: doc/BRIEF.md
# Guarded Low-Power Entry Controller

This block guards the path into low-power operation. It holds a two-bit mode select register and a control register. A stray store must not be able to change the control register. To change it, software first writes a key value to an unlock register. Its very next bus write must go to the control register and carry exactly that value. Any other sequence leaves the control register untouched and raises a sticky error flag. While an unlock is pending, the block tells the interrupt controller to hold off acknowledge, so no handler can run between the two stores.

When an accepted control write sets the sleep request and the mode select holds a valid code, a fixed countdown starts. During the countdown the core is expected to execute filler instructions. The block then reports the chosen low-power state. In that state it watches the interrupt request lines. If wake-by-interrupt is enabled, any request whose mask bit is clear brings the block back to run. The block then gives a one-cycle wake pulse and clears the sleep request. This wake path does not depend on whether the core has interrupts globally enabled.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, all of the following read 0: mode select, control register, error flag, acknowledge hold, low-power state, countdown indicator and wake pulse.
- R2: A bus write to address 0 stores data bits [1:0] into the mode select. Code 2'b01 is halt, 2'b10 is watch, 2'b11 is stop and 2'b00 is reserved.
- R3: A write to address 2 (control) is accepted only if the bus write just before it went to address 1 (unlock) with identical data. An accepted write stores data bit 0 as the sleep request and data bit 1 as wake-by-interrupt enable.
- R4: A control write whose data differs from the unlock data, or that arrives with no unlock pending, leaves the control register unchanged and sets the error flag.
- R5: Any bus write to an address other than 1 cancels a pending unlock, so a control write after it is rejected.
- R6: Writing a 1 in data bit 0 to address 3 clears the error flag. Writing a 0 there leaves the flag unchanged.
- R7: Acknowledge hold is high during an unlock write cycle. It stays high until the cycle of the next bus write, and drops after that write.
- R8: An accepted control write with the sleep request set and a non-reserved mode raises the countdown indicator for exactly 5 cycles. After that, the low-power state output shows the mode code.
- R9: An accepted control write with the sleep request set while the mode is reserved stores the sleep request as 0 and starts no countdown.
- R10: In low power, if wake-by-interrupt is enabled and a request is active with its mask bit at 0, the next cycle shows run, a one-cycle wake pulse and a cleared sleep request. Masked requests, or a cleared enable bit, never wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Write strobe, one transfer per high cycle |
| bus_addr_i | input | 2 | Register address: 0 mode, 1 unlock, 2 control, 3 error clear |
| bus_wdata_i | input | DATA_W | Write data |
| irq_req_i | input | NUM_IRQ | Interrupt request lines |
| irq_mask_i | input | NUM_IRQ | Mask bits, 1 blocks the line from waking |
| mode_sel_o | output | 2 | Mode select register |
| ctrl_o | output | 2 | Control register: bit 1 wake enable, bit 0 sleep request |
| prot_err_o | output | 1 | Sticky rejected-write flag |
| ack_hold_o | output | 1 | Hold off interrupt acknowledge |
| pmode_o | output | 2 | Current low-power state, 0 in run |
| entering_o | output | 1 | Entry countdown in progress |
| wake_pulse_o | output | 1 | One-cycle pulse on return to run |

## Verification
A table of write sequences drives the unlock with several patterns: a proper key-then-control pair, a control write with no key, a key with different data, a key cancelled by a write to another register, and a pair whose mode is reserved. Reading back the control register and error flag after each write shows whether the block accepted the write, rejected it, or accepted it with the sleep request dropped. Directed sequences then count the countdown cycles exactly and follow acknowledge hold across idle cycles. They also check the wake path: first with the active request masked, then with an unmasked request, and then with wake-by-interrupt disabled.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_ERR  = 2'd3;
  localparam logic [1:0] M_RSVD  = 2'b00;
  localparam logic [1:0] M_HALT  = 2'b01;
  localparam logic [1:0] M_WATCH = 2'b10;
  localparam logic [1:0] M_STOP  = 2'b11;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_ENTER = 2'd1, ST_LOW = 2'd2} pst_e;
endpackage

// File: rtl/pwr_unlock.sv
module pwr_unlock
  import pwr_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output logic              err_o,
  output logic              ack_hold_o
);
  logic              armed_q, armed_d;
  logic [DATA_W-1:0] key_q, key_d;
  logic              err_q, err_d;
  logic              key_wr, ctrl_wr, clr_wr;

  always_comb begin
    key_wr   = wr_i && (addr_i == A_KEY);
    ctrl_wr  = wr_i && (addr_i == A_CTRL);
    clr_wr   = wr_i && (addr_i == A_ERR) && data_i[0];
    accept_o = ctrl_wr && armed_q && (data_i == key_q);
    armed_d  = wr_i ? key_wr : armed_q;
    key_d    = key_wr ? data_i : key_q;
    err_d    = err_q;
    if (ctrl_wr && !accept_o) err_d = 1'b1;
    else if (clr_wr)          err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      key_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (key_wr) key_q <= key_d;
      err_q   <= err_d;
    end
  end

  assign err_o      = err_q;
  assign ack_hold_o = armed_q || key_wr;

  // R5
  unlock_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i != A_KEY) |=> !ack_hold_o || (wr_i && addr_i == A_KEY));
  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wr_i && addr_i == A_CTRL));
  // R7
  hold_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_KEY) |=> ack_hold_o);
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_gate_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int ENTRY_CYC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               wake_en_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic               wake_now_o,
  output logic [1:0]         pmode_o,
  output logic               busy_o,
  output logic               wake_pulse_o
);
  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  pst_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       lpm_q, lpm_d;
  logic             wp_q;
  logic             src_hit;

  always_comb begin
    src_hit    = |(irq_i & ~mask_i);
    st_d       = st_q;
    cnt_d      = cnt_q;
    lpm_d      = lpm_q;
    wake_now_o = 1'b0;
    case (st_q)
      ST_RUN: if (start_i) begin
        st_d  = ST_ENTER;
        cnt_d = CNT_W'(ENTRY_CYC - 1);
        lpm_d = mode_i;
      end
      ST_ENTER: if (cnt_q == '0) st_d = ST_LOW;
                else cnt_d = cnt_q - 1'b1;
      ST_LOW: if (wake_en_i && src_hit) begin
        wake_now_o = 1'b1;
        st_d       = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      lpm_q <= M_RSVD;
      wp_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lpm_q <= lpm_d;
      wp_q  <= wake_now_o;
    end
  end

  assign pmode_o      = (st_q == ST_LOW) ? lpm_q : 2'b00;
  assign busy_o       = (st_q == ST_ENTER);
  assign wake_pulse_o = wp_q;

  // R8
  low_via_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_LOW) |-> $past(busy_o));
  // R10
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |=> !wake_pulse_o);
  // R10
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> (pmode_o == 2'b00) && !busy_o);
  // R10
  masked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW && (irq_i & ~mask_i) == '0) |=> st_q == ST_LOW);
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_IRQ   = 4,
  parameter int ENTRY_CYC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  output logic [1:0]         mode_sel_o,
  output logic [1:0]         ctrl_o,
  output logic               prot_err_o,
  output logic               ack_hold_o,
  output logic [1:0]         pmode_o,
  output logic               entering_o,
  output logic               wake_pulse_o
);
  logic [1:0] rs_q;
  logic       rst_s_n;
  logic [1:0] mode_q, mode_d;
  logic [1:0] ctrl_q, ctrl_d;
  logic       accept, wake_now, start, mode_wr, ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pwr_unlock #(.DATA_W(DATA_W)) unlock_i (
    .clk(clk), .rst_n(rst_s_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .data_i(bus_wdata_i), .accept_o(accept), .err_o(prot_err_o),
    .ack_hold_o(ack_hold_o)
  );

  always_comb begin
    mode_wr = bus_wr_i && (bus_addr_i == A_MODE);
    mode_d  = mode_wr ? bus_wdata_i[1:0] : mode_q;
    start   = accept && bus_wdata_i[0] && (mode_q != M_RSVD);
    ctrl_en = accept || wake_now;
    ctrl_d  = ctrl_q;
    if (accept)        ctrl_d = {bus_wdata_i[1], start};
    else if (wake_now) ctrl_d = {ctrl_q[1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= M_RSVD;
      ctrl_q <= 2'b00;
    end else begin
      if (mode_wr) mode_q <= mode_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  pwr_seq #(.NUM_IRQ(NUM_IRQ), .ENTRY_CYC(ENTRY_CYC)) seq_i (
    .clk(clk), .rst_n(rst_s_n), .start_i(start), .mode_i(mode_q),
    .wake_en_i(ctrl_q[1]), .irq_i(irq_req_i), .mask_i(irq_mask_i),
    .wake_now_o(wake_now), .pmode_o(pmode_o), .busy_o(entering_o),
    .wake_pulse_o(wake_pulse_o)
  );

  assign mode_sel_o = mode_q;
  assign ctrl_o     = ctrl_q;

  // R3
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(ctrl_q) |-> $past(bus_wr_i && bus_addr_i == A_CTRL) || wake_pulse_o);
  // R9
  rsvd_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(entering_o) |-> $past(mode_q) != M_RSVD);
endmodule

// File: tb/pwr_gate_ctrl_tb_top.sv
module pwr_gate_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic [3:0] irq = '0, msk = '0;
  logic [1:0] mode_sel, ctrl, pmode;
  logic       err, hold, entering, wake;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwr_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(data), .irq_req_i(irq), .irq_mask_i(msk),
    .mode_sel_o(mode_sel), .ctrl_o(ctrl), .prot_err_o(err),
    .ack_hold_o(hold), .pmode_o(pmode), .entering_o(entering),
    .wake_pulse_o(wake)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; data = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // {req[3:0], addr[1:0], data[7:0], exp ctrl[1:0], exp err}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {4'd3, 2'd1, 8'h02, 2'd0, 1'b0},
    {4'd3, 2'd2, 8'h02, 2'd2, 1'b0},
    {4'd4, 2'd2, 8'h00, 2'd2, 1'b1},
    {4'd6, 2'd3, 8'h01, 2'd2, 1'b0},
    {4'd4, 2'd1, 8'h00, 2'd2, 1'b0},
    {4'd4, 2'd2, 8'h02, 2'd2, 1'b1},
    {4'd6, 2'd3, 8'h00, 2'd2, 1'b1},
    {4'd6, 2'd3, 8'h01, 2'd2, 1'b0},
    {4'd5, 2'd1, 8'h00, 2'd2, 1'b0},
    {4'd5, 2'd0, 8'h00, 2'd2, 1'b0},
    {4'd5, 2'd2, 8'h00, 2'd2, 1'b1},
    {4'd6, 2'd3, 8'h01, 2'd2, 1'b0},
    {4'd9, 2'd1, 8'h03, 2'd2, 1'b0},
    {4'd9, 2'd2, 8'h03, 2'd2, 1'b0},
    {4'd3, 2'd1, 8'h00, 2'd2, 1'b0},
    {4'd3, 2'd2, 8'h00, 2'd0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_sel, 0); chk("R1 ctrl", ctrl, 0);
    chk("R1 err", err, 0);       chk("R1 hold", hold, 0);
    chk("R1 pmode", pmode, 0);   chk("R1 entering", entering, 0);
    chk("R1 wake", wake, 0);

    // Table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][12:11], VEC[i][10:3]);
      chk($sformatf("R%0d ctrl v%0d", VEC[i][16:13], i), ctrl, VEC[i][2:1]);
      chk($sformatf("R%0d err v%0d", VEC[i][16:13], i), err, VEC[i][0]);
      chk($sformatf("R%0d entering v%0d", VEC[i][16:13], i), entering, 0);
    end

    // R7 acknowledge hold window
    @(negedge clk); wr = 1'b1; addr = 2'd1; data = 8'h03;
    #1 chk("R7 hold in key cycle", hold, 1);
    @(negedge clk); wr = 1'b0;
    chk("R7 hold idle", hold, 1);
    @(negedge clk);
    chk("R7 hold idle 2", hold, 1);
    wr = 1'b1; addr = 2'd0; data = 8'h02;
    #1 chk("R7 hold in next write", hold, 1);
    @(negedge clk); wr = 1'b0;
    chk("R7 hold dropped", hold, 0);
    chk("R2 watch code stored", mode_sel, 2);

    // R8 entry countdown into watch
    bus_write(2'd1, 8'h03);
    @(negedge clk); wr = 1'b1; addr = 2'd2; data = 8'h03;
    @(negedge clk); wr = 1'b0;
    chk("R3 ctrl accepted", ctrl, 3);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R8 entering cycle %0d", k), entering, 1);
      chk($sformatf("R8 pmode cycle %0d", k), pmode, 0);
      @(negedge clk);
    end
    chk("R8 countdown ended", entering, 0);
    chk("R8 watch reached", pmode, 2);

    // R10 masked source does not wake
    irq = 4'b0001; msk = 4'b0001;
    repeat (3) @(negedge clk);
    chk("R10 masked no wake", pmode, 2);
    chk("R10 masked no pulse", wake, 0);
    irq = 4'b0011;
    @(negedge clk);
    chk("R10 wake pulse", wake, 1);
    chk("R10 back to run", pmode, 0);
    chk("R10 request cleared", ctrl, 2);
    irq = 4'b0000;
    @(negedge clk);
    chk("R10 pulse one cycle", wake, 0);

    // R2 stop code, then R10 wake disabled
    bus_write(2'd0, 8'hFF);
    chk("R2 stop code stored", mode_sel, 3);
    bus_write(2'd1, 8'h01);
    bus_write(2'd2, 8'h01);
    repeat (6) @(negedge clk);
    chk("R8 stop reached", pmode, 3);
    irq = 4'b0100; msk = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R10 disabled no wake", pmode, 3);
    chk("R10 disabled no pulse", wake, 0);
    chk("R10 disabled ctrl kept", ctrl, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule